// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block holds the bytes a serial receiver has assembled until software picks them up. In queued mode it stores up to sixteen bytes in arrival order, compares the fill level against a programmable threshold, and keeps the receive status bits a line-status read reports: data ready, overrun and break. A byte that arrives at a full queue is discarded and the stored bytes stay as they were. A line break enters the queue as a zero byte. A timeout detector counts character times supplied by an external tick. If the queue holds data and nothing has been received or read for four character times, it raises a pending flag.

With queueing turned off, the block acts as a single holding register. A new byte overwrites the old one, and overrun is raised when the old byte was never read. Writes to the control byte select the mode and the threshold, and can request a flush. A change of mode always flushes and tells the transmit side to flush as well.

Top module: `uart_rxq`

## Requirements
- R1: After reset the queue is off, count and rdData are 0, and dataReady, overrun, breakFlag, timeoutPend, trigHit and txFlush are all low.
- R2: In queued mode, bytes come out on rdData in arrival order. A read (rbrRd) removes the byte that rdData showed before the clock edge, and count follows every accepted push and pop.
- R3: The threshold is taken from control bits 7:6 (00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes) on a control write that has bit 0 set. In queued mode trigHit is high exactly while count is at or above the threshold.
- R4: When a byte arrives at a full queue (16 entries) with no read in the same cycle, the byte is dropped, the stored contents and count are kept, and overrun is set.
- R5: Every received byte sets dataReady and restarts the timeout from zero. A break does not restart the timeout.
- R6: timeoutPend rises on the fourth charTick after the last restart, provided the queue is not empty at that point.
- R7: A data read clears timeoutPend. If bytes remain afterwards, the timeout restarts. If the read empties the queue, the timeout stops.
- R8: A data read from an empty queue returns 0. When the queue becomes empty through a read, dataReady and breakFlag clear.
- R9: A break event (breakEvt, which takes priority over rxValid in the same cycle) pushes a 0x00 byte and sets breakFlag and dataReady. At a full queue it sets overrun like any other byte.
- R10: A control write with bit 1 set empties the queue and clears dataReady, breakFlag and timeoutPend, and leaves overrun unchanged. All other events in a control-write cycle are ignored.
- R11: A control write whose bit 0 differs from the current mode flushes as in R10 and pulses txFlush for one cycle. A write with bit 2 set also pulses txFlush.
- R12: A status read (lsrRd) clears breakFlag and overrun. A set event in the same cycle takes precedence.
- R13: With queueing off, count is 1 while a byte is held and 0 otherwise, and trigHit equals dataReady. A new byte overwrites the held one and sets overrun if dataReady was set with no read in that cycle. A read clears dataReady and breakFlag. timeoutPend stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | A received byte is present on rxByte |
| rxByte | input | 8 | Received byte |
| breakEvt | input | 1 | Line break detected |
| fcrWr | input | 1 | Control byte write strobe |
| fcrData | input | 8 | Control byte: bit 0 queue on, bit 1 receive flush, bit 2 transmit flush, bits 7:6 threshold |
| rbrRd | input | 1 | Data read strobe |
| lsrRd | input | 1 | Status read strobe |
| charTick | input | 1 | One pulse per character time |
| rdData | output | 8 | Byte a read returns now |
| count | output | 5 | Bytes held |
| dataReady | output | 1 | Data ready status |
| overrun | output | 1 | Overrun status |
| breakFlag | output | 1 | Break status |
| timeoutPend | output | 1 | Character timeout pending |
| trigHit | output | 1 | Fill level at or above threshold |
| txFlush | output | 1 | One-cycle flush request to the transmit side |

## Verification
A pointer or count that slips shows up at the next read as a byte out of order, or as a nonzero rdData from a queue that should be empty. The count output shows the error in the cycle after the faulty push or pop. A timeout counter that is off by one raises timeoutPend one tick early or late, and the bench compares every output every cycle, so this is caught on the exact tick. A wrong set/clear priority on the status bits shows up on the first cycle in which an event and a status read coincide.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  typedef struct packed {
    logic push;      // write wrData into the queue tail
    logic pop;       // drop the head entry
    logic flush;     // empty queue and holding register
    logic holdLoad;  // load the single holding register
    logic zeroData;  // write a zero byte instead of rxByte
  } rxqStrobe_t;
endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxqStrobe_t                   stb,
  input  logic [DW-1:0]                rxByte,
  input  logic                         fifoEn,
  output logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  output logic [DW-1:0]                rdData
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] holdReg;
  logic [DW-1:0] wrData;

  assign wrData = stb.zeroData ? '0 : rxByte;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (stb.push && !stb.flush && wrPtr == AW'(g)) mem[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      holdReg <= '0;
    end else if (stb.flush) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      cnt     <= '0;
      holdReg <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      cnt <= cnt + CW'(stb.push) - CW'(stb.pop);
      if (stb.holdLoad) holdReg <= wrData;
    end
  end

  assign fifoCount = cnt;
  assign rdData    = fifoEn ? ((cnt == '0) ? '0 : mem[rdPtr]) : holdReg;

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CW'(DEPTH));
  p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.push && !stb.pop && cnt == CW'(DEPTH)));
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pop && cnt == '0));
endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  parameter int LVL1     = 4,
  parameter int LVL2     = 8,
  parameter int LVL3     = 14
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxValid,
  input  logic                       breakEvt,
  input  logic                       fcrWr,
  input  logic [7:0]                 fcrData,
  input  logic                       rbrRd,
  input  logic                       lsrRd,
  input  logic                       charTick,
  input  logic [$clog2(DEPTH+1)-1:0] fifoCount,
  output rxqStrobe_t                 stb,
  output logic                       fifoEn,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       breakFlag,
  output logic                       timeoutPend,
  output logic                       trigHit,
  output logic                       txFlush
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = (TO_CHARS > 1) ? $clog2(TO_CHARS) : 1;

  logic          fifoEnQ, drQ, oeQ, biQ, pendQ, armedQ, txQ;
  logic [1:0]    trigSel;
  logic [TW-1:0] toCnt;

  logic evOk, modeChg, flushReq, anyPush, rxIn, pop, room, push, lost;
  logic nfOverrun, emptied, restart, disarm, expire;
  logic [CW-1:0] nextCount, lvl;
  logic unusedFcr;

  assign unusedFcr = ^fcrData[5:3];

  assign evOk      = !fcrWr;
  assign modeChg   = fcrWr && (fcrData[0] != fifoEnQ);
  assign flushReq  = fcrWr && (fcrData[1] || modeChg);
  assign anyPush   = evOk && (rxValid || breakEvt);
  assign rxIn      = evOk && rxValid && !breakEvt;
  assign pop       = evOk && fifoEnQ && rbrRd && (fifoCount != '0);
  assign room      = (fifoCount < CW'(DEPTH)) || pop;
  assign push      = fifoEnQ && anyPush && room;
  assign lost      = fifoEnQ && anyPush && !room;
  assign nextCount = fifoCount + CW'(push) - CW'(pop);
  assign nfOverrun = !fifoEnQ && anyPush && drQ && !rbrRd;
  assign emptied   = fifoEnQ ? (pop && nextCount == '0) : (evOk && rbrRd);

  // timeout window
  assign restart = fifoEnQ && (rxIn || (pop && nextCount != '0));
  assign disarm  = pop && (nextCount == '0);
  assign expire  = armedQ && evOk && charTick && (toCnt == TW'(TO_CHARS-1))
                   && !restart && !disarm;

  always_comb begin
    stb          = '0;
    stb.push     = push;
    stb.pop      = pop;
    stb.flush    = flushReq;
    stb.holdLoad = !fifoEnQ && anyPush;
    stb.zeroData = breakEvt;
  end

  always_comb begin
    unique case (trigSel)
      2'b00:   lvl = CW'(1);
      2'b01:   lvl = CW'(LVL1);
      2'b10:   lvl = CW'(LVL2);
      default: lvl = CW'(LVL3);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ <= 1'b0;
      trigSel <= 2'b00;
      drQ     <= 1'b0;
      oeQ     <= 1'b0;
      biQ     <= 1'b0;
      pendQ   <= 1'b0;
      armedQ  <= 1'b0;
      toCnt   <= '0;
      txQ     <= 1'b0;
    end else if (fcrWr) begin
      fifoEnQ <= fcrData[0];
      if (fcrData[0]) trigSel <= fcrData[7:6];
      txQ <= fcrData[2] || modeChg;
      if (flushReq) begin
        drQ    <= 1'b0;
        biQ    <= 1'b0;
        pendQ  <= 1'b0;
        armedQ <= 1'b0;
        toCnt  <= '0;
      end
    end else begin
      txQ <= 1'b0;
      if (lost || nfOverrun) oeQ <= 1'b1;
      else if (lsrRd)        oeQ <= 1'b0;
      if (breakEvt)                biQ <= 1'b1;
      else if (lsrRd || emptied)   biQ <= 1'b0;
      if (anyPush)      drQ <= 1'b1;
      else if (emptied) drQ <= 1'b0;
      if (fifoEnQ && rbrRd)                  pendQ <= 1'b0;
      else if (expire && fifoCount != '0)    pendQ <= 1'b1;
      if (restart) begin
        armedQ <= 1'b1;
        toCnt  <= '0;
      end else if (disarm) begin
        armedQ <= 1'b0;
        toCnt  <= '0;
      end else if (armedQ && charTick) begin
        if (toCnt == TW'(TO_CHARS-1)) begin
          armedQ <= 1'b0;
          toCnt  <= '0;
        end else begin
          toCnt <= toCnt + 1'b1;
        end
      end
    end
  end

  assign fifoEn      = fifoEnQ;
  assign dataReady   = drQ;
  assign overrun     = oeQ;
  assign breakFlag   = biQ;
  assign timeoutPend = pendQ;
  assign txFlush     = txQ;
  assign trigHit     = fifoEnQ ? (fifoCount >= lvl) : drQ;

  p_pend_only_queued_r13: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPend |-> fifoEnQ);
  p_dr_tracks_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    fifoEnQ |-> (dataReady == (fifoCount != '0)));
  p_read_clears_pend_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rbrRd && !fcrWr && fifoEnQ) |=> !timeoutPend);
  p_lost_sets_oe_r4: assert property (@(posedge clk) disable iff (!rstN)
    lost |=> overrun);
  p_lsr_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRd && !fcrWr && !rxValid && !breakEvt) |=> (!overrun && !breakFlag));
  p_break_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    (breakEvt && !fcrWr) |=> (breakFlag && dataReady));
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int DW       = 8,
  parameter int TO_CHARS = 4,
  parameter int LVL1     = 4,
  parameter int LVL2     = 8,
  parameter int LVL3     = 14
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rxValid,
  input  logic [DW-1:0]              rxByte,
  input  logic                       breakEvt,
  input  logic                       fcrWr,
  input  logic [7:0]                 fcrData,
  input  logic                       rbrRd,
  input  logic                       lsrRd,
  input  logic                       charTick,
  output logic [DW-1:0]              rdData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       breakFlag,
  output logic                       timeoutPend,
  output logic                       trigHit,
  output logic                       txFlush
);
  localparam int CW = $clog2(DEPTH+1);

  rxqStrobe_t    stb;
  logic          fifoEn;
  logic [CW-1:0] fifoCount;

  uart_rxq_ctrl #(
    .DEPTH(DEPTH), .TO_CHARS(TO_CHARS), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .breakEvt(breakEvt),
    .fcrWr(fcrWr), .fcrData(fcrData), .rbrRd(rbrRd), .lsrRd(lsrRd),
    .charTick(charTick), .fifoCount(fifoCount), .stb(stb), .fifoEn(fifoEn),
    .dataReady(dataReady), .overrun(overrun), .breakFlag(breakFlag),
    .timeoutPend(timeoutPend), .trigHit(trigHit), .txFlush(txFlush)
  );

  uart_rxq_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte), .fifoEn(fifoEn),
    .fifoCount(fifoCount), .rdData(rdData)
  );

  assign count = fifoEn ? fifoCount : CW'(dataReady);

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fcrWr && fcrData[1]) |=> (count == '0 && !dataReady && !timeoutPend));
  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && count == '0) |-> (rdData == '0));
  p_tx_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> !txFlush || $past(fcrWr));
endmodule

// File: tb/uart_rxq_tb_top.sv
module uart_rxq_tb_top;
  logic clk = 0;
  logic rstN = 0;
  logic rxValid = 0, breakEvt = 0, fcrWr = 0, rbrRd = 0, lsrRd = 0, charTick = 0;
  logic [7:0] rxByte = 0, fcrData = 0;
  logic [7:0] rdData;
  logic [4:0] count;
  logic dataReady, overrun, breakFlag, timeoutPend, trigHit, txFlush;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state
  logic [7:0] q[$];
  bit mEn = 0, mDr = 0, mOe = 0, mBi = 0, mPend = 0, mArmed = 0, mTx = 0;
  logic [1:0] mTrig = 0;
  logic [7:0] mHold = 0;
  int mCnt = 0;

  always #5 clk = ~clk;

  uart_rxq dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .breakEvt(breakEvt),
    .fcrWr(fcrWr), .fcrData(fcrData), .rbrRd(rbrRd), .lsrRd(lsrRd), .charTick(charTick),
    .rdData(rdData), .count(count), .dataReady(dataReady), .overrun(overrun),
    .breakFlag(breakFlag), .timeoutPend(timeoutPend), .trigHit(trigHit), .txFlush(txFlush)
  );

  function automatic int lvlOf(logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction
  function automatic logic [7:0] expRd();
    if (mEn) return (q.size() > 0) ? q[0] : 8'h00;
    return mHold;
  endfunction
  function automatic int expCount();
    return mEn ? q.size() : int'(mDr);
  endfunction
  function automatic bit expTrig();
    return mEn ? (q.size() >= lvlOf(mTrig)) : mDr;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    cmp(tag, "rdData", rdData, expRd());
    cmp(tag, "count", count, expCount());
    cmp(tag, "dataReady", dataReady, mDr);
    cmp(tag, "overrun", overrun, mOe);
    cmp(tag, "breakFlag", breakFlag, mBi);
    cmp(tag, "timeoutPend", timeoutPend, mPend);
    cmp(tag, "trigHit", trigHit, expTrig());
    cmp(tag, "txFlush", txFlush, mTx);
  endtask

  task automatic modelStep(bit rx, logic [7:0] rb, bit brk, bit fcw, logic [7:0] fcd,
                           bit rbr, bit lsr, bit tick);
    bit anyPush, pop, lost, chg, drBefore, restart, disarm;
    logic [7:0] d;
    int newc;
    mTx = 0;
    if (fcw) begin
      chg = (fcd[0] != mEn);
      mTx = fcd[2] | chg;
      if (fcd[1] | chg) begin
        q.delete(); mDr = 0; mBi = 0; mPend = 0; mArmed = 0; mCnt = 0; mHold = 0;
      end
      mEn = fcd[0];
      if (fcd[0]) mTrig = fcd[7:6];
      return;
    end
    anyPush = rx | brk;
    d = brk ? 8'h00 : rb;
    if (mEn) begin
      pop = rbr && q.size() > 0;
      lost = 0;
      if (pop) void'(q.pop_front());
      if (anyPush) begin
        if (q.size() < 16) q.push_back(d); else lost = 1;
      end
      newc = q.size();
      if (lsr) begin mOe = 0; mBi = 0; end
      if (lost) mOe = 1;
      if (pop && newc == 0) begin mDr = 0; mBi = 0; end
      if (anyPush) mDr = 1;
      if (brk) mBi = 1;
      if (rbr) mPend = 0;
      restart = (rx && !brk) || (pop && newc != 0);
      disarm = pop && newc == 0;
      if (restart) begin mArmed = 1; mCnt = 0; end
      else if (disarm) begin mArmed = 0; mCnt = 0; end
      else if (mArmed && tick) begin
        if (mCnt == 3) begin
          mArmed = 0; mCnt = 0;
          if (newc > 0 && !rbr) mPend = 1;
        end else mCnt++;
      end
    end else begin
      drBefore = mDr;
      if (lsr) begin mOe = 0; mBi = 0; end
      if (rbr) begin mDr = 0; mBi = 0; end
      if (anyPush) begin
        if (drBefore && !rbr) mOe = 1;
        mHold = d; mDr = 1;
        if (brk) mBi = 1;
      end
    end
  endtask

  // one clock: drive at negedge, check rdData before the edge, update model, check after
  task automatic cyc(string tag, bit rx = 0, logic [7:0] rb = 0, bit brk = 0,
                     bit fcw = 0, logic [7:0] fcd = 0, bit rbr = 0, bit lsr = 0,
                     bit tick = 0);
    rxValid = rx; rxByte = rb; breakEvt = brk; fcrWr = fcw; fcrData = fcd;
    rbrRd = rbr; lsrRd = lsr; charTick = tick;
    #1;
    if (rbr) cmp(tag, "rdData-before-read", rdData, expRd());
    @(negedge clk);
    modelStep(rx, rb, brk, fcw, fcd, rbr, lsr, tick);
    rxValid = 0; breakEvt = 0; fcrWr = 0; rbrRd = 0; lsrRd = 0; charTick = 0;
    checkAll(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkAll("R1");

    // R13: holding register mode
    cyc("R13", .rx(1), .rb(8'hA1));
    cyc("R13", .rx(1), .rb(8'hB2));
    cyc("R13", .rbr(1));
    cyc("R13", .lsr(1));
    cyc("R13", .brk(1));
    cyc("R13", .rbr(1));

    // R11: mode change flushes and pulses transmit flush
    cyc("R11", .fcw(1), .fcd(8'h01));
    cyc("R11");

    // R2/R3/R4: fill, overflow, drain in order
    for (int i = 0; i < 16; i++) cyc("R2", .rx(1), .rb(8'(8'h10 + i)));
    cyc("R4", .rx(1), .rb(8'hEE));
    cyc("R4", .lsr(1));
    for (int i = 0; i < 16; i++) cyc("R2", .rbr(1));
    cyc("R8", .rbr(1));

    // R3: each threshold
    for (int s = 1; s < 4; s++) begin
      cyc("R3", .fcw(1), .fcd(8'((s << 6) | 3)));
      for (int i = 0; i < 15; i++) cyc("R3", .rx(1), .rb(8'(i)));
    end
    cyc("R3", .fcw(1), .fcd(8'h03));
    cyc("R3", .rx(1), .rb(8'h55));

    // R6/R7: timeout
    cyc("R10", .fcw(1), .fcd(8'h03));
    cyc("R5", .rx(1), .rb(8'h01));
    cyc("R5", .rx(1), .rb(8'h02), .tick(1));
    for (int i = 0; i < 4; i++) cyc("R6", .tick(1));
    cyc("R7", .rbr(1));
    for (int i = 0; i < 4; i++) cyc("R7", .tick(1));
    cyc("R7", .rbr(1));
    for (int i = 0; i < 5; i++) cyc("R7", .tick(1));

    // R9/R12: break handling, set wins over status read
    cyc("R9", .brk(1), .rx(1), .rb(8'h77));
    cyc("R12", .lsr(1));
    cyc("R12", .brk(1), .lsr(1));
    for (int i = 0; i < 6; i++) cyc("R5", .tick(1));
    cyc("R8", .rbr(1));
    cyc("R8", .rbr(1));

    // R10: flush keeps overrun, ignores same-cycle receive
    for (int i = 0; i < 17; i++) cyc("R10", .rx(1), .rb(8'(i)));
    cyc("R10", .fcw(1), .fcd(8'h03), .rx(1), .rb(8'h99));
    cyc("R11", .fcw(1), .fcd(8'h05));
    cyc("R11", .fcw(1), .fcd(8'h00));

    // random mix
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 30)      cyc("R2", .rx(1), .rb(8'($urandom)), .tick($urandom_range(0, 3) == 0));
      else if (r < 50) cyc("R7", .rbr(1), .tick($urandom_range(0, 3) == 0));
      else if (r < 80) cyc("R6", .tick(1));
      else if (r < 83) cyc("R9", .brk(1));
      else if (r < 91) cyc("R12", .lsr(1), .rx($urandom_range(0, 4) == 0), .rb(8'($urandom)));
      else if (r < 93) cyc("R10", .fcw(1),
                           .fcd(8'({$urandom_range(0, 3), 5'b0, ($urandom_range(0, 6) != 0)}
                                    | ($urandom_range(0, 3) == 0 ? 8'h02 : 8'h00)
                                    | ($urandom_range(0, 3) == 0 ? 8'h04 : 8'h00))));
      else             cyc("R13");
    end

    finished = 1;
    summary();
  end
endmodule